// File: doc/BRIEF.md
# Mixed-Width True Dual-Port Bit Memory

This block is a synchronous store of 4096 bits reached through two independent ports, A and B. Each port has its own clock, enable, write enable, output clear, address, write data and read data. A parameter fixes each port's word width at 1, 2, 4, 8 or 16 bits, and the two widths may differ. Both ports address the same bit cells, so a word written at one width can be read back through the other port at another width.

Each port registers its result on the rising edge of its own clock. A write also places the written word on that port's output in the same edge. The output clear zeroes only the port's output register. It leaves the stored bits alone and does not disturb a write on the other port.

Top module: `mixed_dpram`

## Requirements
- R1: A port of width W (1, 2, 4, 8 or 16) has 12 − log2(W) address bits and 4096/W words, and its highest address reaches the last W bits of the store.
- R2: The word at address a on a port of width W holds store bits a·W up to a·W+W−1, with word bit 0 at store bit a·W. With port A at 4 bits and port B at 8 bits, B word k equals {A word 2k+1, A word 2k}.
- R3: Every input of a port is sampled on the rising edge of that port's clock, and that port's output changes only on that edge.
- R4: While a port's enable is low at an edge, that port stores nothing, ignores its clear, and keeps its output unchanged.
- R5: With enable and write enable high and clear low, the write data is stored at the addressed word and also appears on the same port's output after the edge.
- R6: With enable high and both write enable and clear low, the stored word at the address appears on the output after the edge.
- R7: With enable and clear high, the port's output becomes zero after the edge, and the stored bits stay unchanged.
- R8: With enable, write enable and clear all high, the write is still stored but the port's output becomes zero.
- R9: A clear on one port does not disturb a write made by the other port in the same cycle.
- R10: Both ports writing overlapping bits in the same cycle leave those bits undefined and are flagged by an assertion. A read of bits that the other port writes in the same cycle returns an undefined value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock, rising edge |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| rst_a | input | 1 | Port A synchronous output clear |
| addr_a | input | 12 − log2(WIDTH_A) | Port A word address |
| din_a | input | WIDTH_A | Port A write data |
| dout_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock, rising edge |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| rst_b | input | 1 | Port B synchronous output clear |
| addr_b | input | 12 − log2(WIDTH_B) | Port B word address |
| din_b | input | WIDTH_B | Port B write data |
| dout_b | output | WIDTH_B | Port B registered read data |

## Verification
Every result of a port, whether read data, written data or a cleared output, is due at that port's output exactly one rising edge after the inputs that cause it, and a disabled port's output keeps its value for as long as the enable stays low. The bench changes inputs on the falling edge and compares the outputs 1 ns after the next rising edge. Before that edge it computes the expected word from its own bit model of the store, and it updates the model only after the comparison. Through disabled cycles it keeps the last expected value, and it skips the comparison for a read of bits that the other port writes in the same cycle.

// File: rtl/mixed_dpram.sv
module mixed_dpram #(
  parameter int WIDTH_A = 4,
  parameter int WIDTH_B = 8,
  localparam int LOG_A = $clog2(WIDTH_A),
  localparam int LOG_B = $clog2(WIDTH_B),
  localparam int AW_A  = 12 - LOG_A,
  localparam int AW_B  = 12 - LOG_B
) (
  input  logic               clk_a,
  input  logic               en_a,
  input  logic               we_a,
  input  logic               rst_a,
  input  logic [AW_A-1:0]    addr_a,
  input  logic [WIDTH_A-1:0] din_a,
  output logic [WIDTH_A-1:0] dout_a,
  input  logic               clk_b,
  input  logic               en_b,
  input  logic               we_b,
  input  logic               rst_b,
  input  logic [AW_B-1:0]    addr_b,
  input  logic [WIDTH_B-1:0] din_b,
  output logic [WIDTH_B-1:0] dout_b
);
  localparam int BITS = 4096;

  // Each port owns one bank; a stored bit is the XOR of both banks.
  logic [BITS-1:0] bank_a;
  logic [BITS-1:0] bank_b;
  logic [BITS-1:0] cells;
  logic [11:0]     base_a;
  logic [11:0]     base_b;

  assign cells  = bank_a ^ bank_b;
  assign base_a = 12'(addr_a) << LOG_A;
  assign base_b = 12'(addr_b) << LOG_B;

  always_ff @(posedge clk_a) begin
    if (en_a) begin
      if (we_a) bank_a[base_a +: WIDTH_A] <= din_a ^ bank_b[base_a +: WIDTH_A];
      if (rst_a)     dout_a <= '0;
      else if (we_a) dout_a <= din_a;
      else           dout_a <= cells[base_a +: WIDTH_A];
    end
  end

  always_ff @(posedge clk_b) begin
    if (en_b) begin
      if (we_b) bank_b[base_b +: WIDTH_B] <= din_b ^ bank_a[base_b +: WIDTH_B];
      if (rst_b)     dout_b <= '0;
      else if (we_b) dout_b <= din_b;
      else           dout_b <= cells[base_b +: WIDTH_B];
    end
  end

  // Checks, active once each port has seen a first edge.
  logic live_a = 1'b0;
  logic live_b = 1'b0;
  always_ff @(posedge clk_a) live_a <= 1'b1;
  always_ff @(posedge clk_b) live_b <= 1'b1;

  logic clash;
  assign clash = en_a && we_a && en_b && we_b &&
                 (int'(base_a) < int'(base_b) + WIDTH_B) &&
                 (int'(base_b) < int'(base_a) + WIDTH_A);

  assert_hold_a_R4: assert property (@(posedge clk_a) disable iff (!live_a)
    !en_a |=> $stable(dout_a));
  assert_hold_b_R4: assert property (@(posedge clk_b) disable iff (!live_b)
    !en_b |=> $stable(dout_b));
  assert_clear_a_R7: assert property (@(posedge clk_a) disable iff (!live_a)
    en_a && rst_a |=> dout_a == '0);
  assert_clear_b_R7: assert property (@(posedge clk_b) disable iff (!live_b)
    en_b && rst_b |=> dout_b == '0);
  assert_echo_a_R5: assert property (@(posedge clk_a) disable iff (!live_a)
    en_a && we_a && !rst_a |=> dout_a == $past(din_a));
  assert_echo_b_R5: assert property (@(posedge clk_b) disable iff (!live_b)
    en_b && we_b && !rst_b |=> dout_b == $past(din_b));
  assert_no_write_clash_R10: assert property (@(posedge clk_a) disable iff (!live_a)
    !clash);
endmodule

// File: tb/mixed_dpram_test.sv
module mixed_dpram_test;
  localparam int WA = 4;
  localparam int WB = 8;
  localparam int AA = 10;
  localparam int AB = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic en_a = 0, we_a = 0, rst_a = 0;
  logic en_b = 0, we_b = 0, rst_b = 0;
  logic [AA-1:0] addr_a = '0;
  logic [AB-1:0] addr_b = '0;
  logic [WA-1:0] din_a = '0, dout_a;
  logic [WB-1:0] din_b = '0, dout_b;

  mixed_dpram #(.WIDTH_A(WA), .WIDTH_B(WB)) uut (
    .clk_a(clk), .en_a(en_a), .we_a(we_a), .rst_a(rst_a), .addr_a(addr_a),
    .din_a(din_a), .dout_a(dout_a),
    .clk_b(clk), .en_b(en_b), .we_b(we_b), .rst_b(rst_b), .addr_b(addr_b),
    .din_b(din_b), .dout_b(dout_b));

  bit [4095:0] model;
  logic [WA-1:0] exp_a; bit ok_a = 0;
  logic [WB-1:0] exp_b; bit ok_b = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit overlap(int ba, int bb);
    return (ba < bb + WB) && (bb < ba + WA);
  endfunction

  task automatic tick(string tag = "");
    int ba = int'(addr_a) * WA;
    int bb = int'(addr_b) * WB;
    bit ov = overlap(ba, bb);
    string ta = "R4", tb = "R4";
    if (en_a) begin
      if (rst_a)     begin exp_a = '0; ok_a = 1; ta = "R7"; end
      else if (we_a) begin exp_a = din_a; ok_a = 1; ta = "R5"; end
      else begin exp_a = model[ba +: WA]; ok_a = !(en_b && we_b && ov); ta = "R6"; end
    end
    if (en_b) begin
      if (rst_b)     begin exp_b = '0; ok_b = 1; tb = "R7"; end
      else if (we_b) begin exp_b = din_b; ok_b = 1; tb = "R5"; end
      else begin exp_b = model[bb +: WB]; ok_b = !(en_a && we_a && ov); tb = "R2"; end
    end
    if (tag != "") begin ta = tag; tb = tag; end
    @(posedge clk);
    #1;
    if (ok_a) chk({ta, " port A"}, 32'(dout_a), 32'(exp_a));
    if (ok_b) chk({tb, " port B"}, 32'(dout_b), 32'(exp_b));
    if (en_a && we_a) model[ba +: WA] = din_a;
    if (en_b && we_b) model[bb +: WB] = din_b;
    @(negedge clk);
  endtask

  task automatic idle();
    en_a = 0; we_a = 0; rst_a = 0; en_b = 0; we_b = 0; rst_b = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    @(negedge clk);
    // Reset state: clear both outputs (R7)
    en_a = 1; rst_a = 1; en_b = 1; rst_b = 1;
    tick("R7");
    idle();
    // Fill the store through port B (R5, R1)
    for (int k = 0; k < 512; k++) begin
      en_b = 1; we_b = 1; addr_b = AB'(k); din_b = WB'($urandom);
      tick("R1");
    end
    idle();
    // Cross-width mapping (R2): A writes nibbles 2k and 2k+1, B reads word k
    en_a = 1; we_a = 1; addr_a = 10'd20; din_a = 4'h3; tick("R5");
    addr_a = 10'd21; din_a = 4'hC; tick("R5");
    idle(); en_b = 1; addr_b = 9'd10; tick("R2");
    chk("R2 mapping", 32'(dout_b), 32'h00C3);
    // Top address (R1)
    idle(); en_a = 1; we_a = 1; addr_a = 10'd1023; din_a = 4'hA; tick("R1");
    idle(); en_b = 1; addr_b = 9'd511; tick("R1");
    chk("R1 top word", 32'(dout_b[7:4]), 32'hA);
    // Disabled port: no write, clear ignored, output held (R4)
    idle(); en_a = 1; addr_a = 10'd5; tick("R6");
    idle(); we_a = 1; rst_a = 1; addr_a = 10'd5; din_a = ~model[20 +: 4]; tick("R4");
    tick("R4");
    idle(); en_a = 1; addr_a = 10'd5; tick("R4");
    // Clear leaves store unchanged (R7)
    idle(); en_a = 1; rst_a = 1; addr_a = 10'd7; tick("R7");
    idle(); en_a = 1; addr_a = 10'd7; tick("R7");
    // Clear plus write: stored, output zero (R8)
    idle(); en_a = 1; we_a = 1; rst_a = 1; addr_a = 10'd40; din_a = 4'h9; tick("R8");
    idle(); en_b = 1; addr_b = 9'd20; tick("R8");
    chk("R8 stored nibble", 32'(dout_b[3:0]), 32'h9);
    // Clear on A while B writes (R9)
    idle(); en_a = 1; rst_a = 1; addr_a = 10'd100;
    en_b = 1; we_b = 1; addr_b = 9'd50; din_b = 8'h5E; tick("R9");
    idle(); en_a = 1; addr_a = 10'd100; tick("R9");
    addr_a = 10'd101; tick("R9");
    // Random traffic (R3, R5, R6, R2, R4)
    for (int i = 0; i < 4000; i++) begin
      en_a = ($urandom % 4) != 0; we_a = $urandom % 2; rst_a = ($urandom % 16) == 0;
      en_b = ($urandom % 4) != 0; we_b = $urandom % 2; rst_b = ($urandom % 16) == 0;
      addr_a = AA'($urandom % 64); addr_b = AB'($urandom % 32);
      din_a = WA'($urandom); din_b = WB'($urandom);
      if (en_a && we_a && en_b && we_b && overlap(int'(addr_a) * WA, int'(addr_b) * WB))
        we_b = 0;
      tick();
    end
    idle(); tick("R3");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule